// File: doc/BRIEF.md
# Display Power and Backlight Sequencer

This block orders the supplies and control lines of a flat-panel display module and its LED backlight converter. It drives the panel supply enable and the enable that lets the video link carry valid signals. It also drives the converter supply enable, a dimming PWM output and the backlight-on line. All delays are counted in pulses of a 1 ms tick input. The PWM period comes from a system-clock prescaler.

On power-up the panel supply rises first. After a short delay the video link is enabled. After the long settling time the converter supply, the PWM and finally the backlight-on line follow, each after its own delay. Power-down runs the same chain in reverse. Once the panel supply has been removed it must stay off for a minimum time before it can return. Dropping the enable part-way through power-up starts the power-down chain at the highest output that is currently on.

A converter error line reads low when the converter is healthy and high when its protection trips. The line is synchronised. A trip while the converter supply is on forces a full power-down and latches a fault flag. The PWM duty comes from an 8-bit command. The command is sampled only while the block is fully off or fully on, and a floor of about 5% is applied to it. The default delays meet a 0 to 50 ms panel-to-video window, a 500 ms gap from video valid to backlight on, and a 500 ms supply-off time. The default prescaler gives about 160 Hz from a 50 MHz clock.

Top module: `disp_pwr_seq`

## Requirements
- R1: While reset is asserted, and directly after it is released, every output is low: panel supply, link enable, converter supply, PWM, backlight-on and fault.
- R2: With enable high from idle, the panel supply rises on the first clock edge. The link enable rises after T_P2L ticks. The converter supply rises T_L2B ticks after that. The PWM starts T_B2P ticks after that. Backlight-on rises T_P2O ticks after that. Outputs never turn on out of this order.
- R3: When enable falls in the fully-on state, backlight-on drops on the next edge. The PWM stops T_DSTEP ticks later and the converter supply drops T_DSTEP ticks after that. The link enable drops T_DSTEP ticks after that, and the panel supply drops T_L2P ticks after the link.
- R4: Once the panel supply falls, it stays off for T_HOLD ticks even if enable is high. After reset the hold counts as already done.
- R5: While the PWM runs, its period is 256 steps of PWM_DIV clocks. It is high for the first D steps of each period, where D is the effective duty. Each run starts at step 0, and the output is low whenever the PWM is not running.
- R6: The duty command is captured only in the idle and fully-on states. Changes made during a power-up or power-down ramp do not alter the PWM.
- R7: An effective duty below DUTY_MIN (13 of 256, about 5%) is raised to DUTY_MIN.
- R8: The error input passes through a two-flop synchroniser. If the synchronised error is high while the converter supply is on, fault rises and power-down starts. Fault and the off state are held while enable stays high, and fault clears when enable is low.
- R9: If enable falls during the power-up ramp, the highest output already on is dropped on the next edge. The descent then goes on from there without waiting for outputs that never turned on.
- R10: A high error input while the converter supply is off sets no fault and does not stop the power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Request to power the display |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| duty_i | input | 8 | Dimming duty command, out of 256 |
| conv_err_i | input | 1 | Converter error line, high on a protection trip |
| panel_pwr_o | output | 1 | Panel supply enable |
| link_en_o | output | 1 | Video link valid enable |
| bl_pwr_o | output | 1 | Converter supply enable |
| pwm_o | output | 1 | Dimming PWM |
| bl_on_o | output | 1 | Backlight on |
| fault_o | output | 1 | Latched converter fault |

## Verification
The sequencer is driven with a tick that comes every third clock, so that tick counting is kept apart from clock counting. Complete power-up and power-down runs check the order and delays in both directions. A re-enable issued straight after power-down tests the supply-off hold. Aborts taken in the link-settle and converter-supply phases show that the descent starts at the right output. A small duty command that is changed during the ramp tells the capture windows and the 5% floor apart from plain pass-through. An error held high before the converter is powered, and an error raised in the on state, tell the ignored case from the latched fault.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_UP_PANEL,
    ST_UP_LINK,
    ST_UP_BLPWR,
    ST_UP_PWM,
    ST_ON,
    ST_DN_BLON,
    ST_DN_PWM,
    ST_DN_BLPWR,
    ST_DN_LINK
  } dps_state_e;

  function automatic int dps_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dps_sync2.sv
module dps_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/dps_seq_fsm.sv
module dps_seq_fsm
  import dps_pkg::*;
#(
  parameter int T_P2L   = 20,
  parameter int T_L2B   = 501,
  parameter int T_B2P   = 10,
  parameter int T_P2O   = 10,
  parameter int T_DSTEP = 10,
  parameter int T_L2P   = 20,
  parameter int T_HOLD  = 501
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       err_i,
  output dps_state_e state_o,
  output logic       fault_o
);

  localparam int MAXT = dps_max(dps_max(dps_max(T_P2L, T_L2B), dps_max(T_B2P, T_P2O)),
                                dps_max(dps_max(T_DSTEP, T_L2P), T_HOLD));
  localparam int CW   = $clog2(MAXT + 1);

  dps_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          fault_q, fault_d;
  logic          conv_on, abort, done, hold_ok;

  always_comb begin
    case (st_q)
      ST_UP_PANEL: lim_m1 = CW'(T_P2L - 1);
      ST_UP_LINK:  lim_m1 = CW'(T_L2B - 1);
      ST_UP_BLPWR: lim_m1 = CW'(T_B2P - 1);
      ST_UP_PWM:   lim_m1 = CW'(T_P2O - 1);
      ST_DN_BLON,
      ST_DN_PWM,
      ST_DN_BLPWR: lim_m1 = CW'(T_DSTEP - 1);
      ST_DN_LINK:  lim_m1 = CW'(T_L2P - 1);
      default:     lim_m1 = '0;
    endcase
  end

  assign conv_on = (st_q == ST_UP_BLPWR) || (st_q == ST_UP_PWM) || (st_q == ST_ON) ||
                   (st_q == ST_DN_BLON)  || (st_q == ST_DN_PWM);
  assign done    = tick_i && (cnt_q == lim_m1);
  assign hold_ok = (cnt_q >= CW'(T_HOLD));
  assign abort   = !en_i || fault_q || (err_i && conv_on);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:      if (en_i && !fault_q && hold_ok) st_d = ST_UP_PANEL;
      ST_UP_PANEL: if (abort) st_d = ST_OFF;      else if (done) st_d = ST_UP_LINK;
      ST_UP_LINK:  if (abort) st_d = ST_DN_LINK;  else if (done) st_d = ST_UP_BLPWR;
      ST_UP_BLPWR: if (abort) st_d = ST_DN_BLPWR; else if (done) st_d = ST_UP_PWM;
      ST_UP_PWM:   if (abort) st_d = ST_DN_PWM;   else if (done) st_d = ST_ON;
      ST_ON:       if (abort) st_d = ST_DN_BLON;
      ST_DN_BLON:  if (done) st_d = ST_DN_PWM;
      ST_DN_PWM:   if (done) st_d = ST_DN_BLPWR;
      ST_DN_BLPWR: if (done) st_d = ST_DN_LINK;
      ST_DN_LINK:  if (done) st_d = ST_OFF;
      default:     st_d = ST_OFF;
    endcase
  end

  always_comb begin
    if (st_d != st_q)                         cnt_d = '0;
    else if (tick_i && (cnt_q != CW'(MAXT)))  cnt_d = cnt_q + 1'b1;
    else                                      cnt_d = cnt_q;
  end

  always_comb begin
    if (!en_i)                 fault_d = 1'b0;
    else if (err_i && conv_on) fault_d = 1'b1;
    else                       fault_d = fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      cnt_q   <= CW'(T_HOLD);
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign state_o = st_q;
  assign fault_o = fault_q;

endmodule

// File: rtl/dps_pwm.sv
module dps_pwm #(
  parameter int DIV      = 1221,
  parameter int DUTY_W   = 8,
  parameter int DUTY_MIN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              take_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);

  localparam int              PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DUTY_W-1:0] DMIN = DUTY_W'(DUTY_MIN);

  logic [PW-1:0]     pre_q, pre_d;
  logic [DUTY_W-1:0] step_q, step_d, duty_q, duty_d, duty_eff;

  always_comb begin
    duty_d = take_i ? duty_i : duty_q;
    if (!run_i) begin
      pre_d  = '0;
      step_d = '0;
    end else if (pre_q == PW'(DIV - 1)) begin
      pre_d  = '0;
      step_d = step_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
      step_d = step_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
      duty_q <= '0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
      duty_q <= duty_d;
    end
  end

  assign duty_eff = (duty_q < DMIN) ? DMIN : duty_q;
  assign pwm_o    = run_i && (step_q < duty_eff);

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dps_pkg::*;
#(
  parameter int T_P2L    = 20,
  parameter int T_L2B    = 501,
  parameter int T_B2P    = 10,
  parameter int T_P2O    = 10,
  parameter int T_DSTEP  = 10,
  parameter int T_L2P    = 20,
  parameter int T_HOLD   = 501,
  parameter int PWM_DIV  = 1221,
  parameter int DUTY_W   = 8,
  parameter int DUTY_MIN = 13,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              conv_err_i,
  output logic              panel_pwr_o,
  output logic              link_en_o,
  output logic              bl_pwr_o,
  output logic              pwm_o,
  output logic              bl_on_o,
  output logic              fault_o
);

  dps_state_e st;
  logic       err_s, pwm_run, duty_take;

  dps_sync2 #(.STAGES(SYNC_STG)) u_err_sync (
    .clk(clk), .rst_n(rst_n), .d_i(conv_err_i), .q_o(err_s)
  );

  dps_seq_fsm #(
    .T_P2L(T_P2L), .T_L2B(T_L2B), .T_B2P(T_B2P), .T_P2O(T_P2O),
    .T_DSTEP(T_DSTEP), .T_L2P(T_L2P), .T_HOLD(T_HOLD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .err_i(err_s),
    .state_o(st), .fault_o(fault_o)
  );

  assign panel_pwr_o = (st != ST_OFF);
  assign link_en_o   = (st != ST_OFF) && (st != ST_UP_PANEL) && (st != ST_DN_LINK);
  assign bl_pwr_o    = (st == ST_UP_BLPWR) || (st == ST_UP_PWM) || (st == ST_ON) ||
                       (st == ST_DN_BLON)  || (st == ST_DN_PWM);
  assign pwm_run     = (st == ST_UP_PWM) || (st == ST_ON) || (st == ST_DN_BLON);
  assign bl_on_o     = (st == ST_ON);
  assign duty_take   = (st == ST_OFF) || (st == ST_ON);

  dps_pwm #(.DIV(PWM_DIV), .DUTY_W(DUTY_W), .DUTY_MIN(DUTY_MIN)) u_pwm (
    .clk(clk), .rst_n(rst_n), .run_i(pwm_run), .take_i(duty_take),
    .duty_i(duty_i), .pwm_o(pwm_o)
  );

endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk #(
  parameter int T_HOLD = 501
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic tick_i,
  input logic panel_pwr_o,
  input logic link_en_o,
  input logic bl_pwr_o,
  input logic pwm_o,
  input logic bl_on_o,
  input logic fault_o
);

  int off_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         off_ticks <= T_HOLD;
    else if (panel_pwr_o)               off_ticks <= 0;
    else if (tick_i && off_ticks < T_HOLD) off_ticks <= off_ticks + 1;
  end

  // R2
  link_needs_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_en_o |-> panel_pwr_o);

  // R2
  conv_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bl_pwr_o |-> link_en_o);

  // R2
  blon_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_on_o) |-> $past(bl_pwr_o));

  // R3
  conv_off_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bl_pwr_o) |-> (!bl_on_o && !pwm_o));

  // R5
  pwm_needs_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_o |-> bl_pwr_o);

  // R4
  panel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_pwr_o) |-> (off_ticks >= T_HOLD));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && en_i) |=> fault_o);

  // R8
  fault_no_blon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !bl_on_o);

endmodule

bind disp_pwr_seq disp_pwr_seq_chk #(.T_HOLD(T_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i),
  .panel_pwr_o(panel_pwr_o), .link_en_o(link_en_o), .bl_pwr_o(bl_pwr_o),
  .pwm_o(pwm_o), .bl_on_o(bl_on_o), .fault_o(fault_o)
);

// File: tb/disp_pwr_seq_tb.sv
`timescale 1ns/1ps
module disp_pwr_seq_tb;

  localparam int P_P2L = 3, P_L2B = 20, P_B2P = 2, P_P2O = 20;
  localparam int P_DSTEP = 2, P_L2P = 3, P_HOLD = 15, P_DIV = 2, P_DMIN = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic tick_i = 1'b0;
  logic [7:0] duty_i = 8'd0;
  logic conv_err_i = 1'b0;
  logic panel_pwr_o, link_en_o, bl_pwr_o, pwm_o, bl_on_o, fault_o;

  int checks = 0;
  int errors = 0;
  int tick_div = 0;

  always #10 clk = ~clk;

  disp_pwr_seq #(
    .T_P2L(P_P2L), .T_L2B(P_L2B), .T_B2P(P_B2P), .T_P2O(P_P2O),
    .T_DSTEP(P_DSTEP), .T_L2P(P_L2P), .T_HOLD(P_HOLD),
    .PWM_DIV(P_DIV), .DUTY_W(8), .DUTY_MIN(P_DMIN), .SYNC_STG(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .duty_i(duty_i),
    .conv_err_i(conv_err_i), .panel_pwr_o(panel_pwr_o), .link_en_o(link_en_o),
    .bl_pwr_o(bl_pwr_o), .pwm_o(pwm_o), .bl_on_o(bl_on_o), .fault_o(fault_o)
  );

  // tick every third clock
  always @(negedge clk) begin
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    tick_i   = (tick_div == 2);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 panel,2 link,3 conv,4 pwm,5 on,6..9 descent
  int  m_ph, m_cnt, m_duty, m_pre, m_step;
  bit  m_fault, m_e1, m_e2;

  function automatic int ph_len(input int ph);
    case (ph)
      1: return P_P2L;
      2: return P_L2B;
      3: return P_B2P;
      4: return P_P2O;
      6, 7, 8: return P_DSTEP;
      9: return P_L2P;
      default: return 0;
    endcase
  endfunction

  function automatic bit ex_link(input int ph);  return (ph >= 2 && ph <= 8); endfunction
  function automatic bit ex_conv(input int ph);  return (ph >= 3 && ph <= 7); endfunction
  function automatic bit ex_run(input int ph);   return (ph >= 4 && ph <= 6); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = P_HOLD; m_fault = 0; m_e1 = 0; m_e2 = 0;
      m_duty = 0; m_pre = 0; m_step = 0;
    end else begin
      int  ph_o, nph, nf;
      bit  conv, stop, fin;
      ph_o = m_ph;
      conv = ex_conv(ph_o);
      stop = !en_i || m_fault || (m_e2 && conv);
      fin  = tick_i && (m_cnt + 1 == ph_len(ph_o));
      nph  = ph_o;
      case (ph_o)
        0: if (en_i && !m_fault && m_cnt >= P_HOLD) nph = 1;
        1: nph = stop ? 0 : (fin ? 2 : 1);
        2: nph = stop ? 9 : (fin ? 3 : 2);
        3: nph = stop ? 8 : (fin ? 4 : 3);
        4: nph = stop ? 7 : (fin ? 5 : 4);
        5: nph = stop ? 6 : 5;
        6, 7, 8: nph = fin ? ph_o + 1 : ph_o;
        9: nph = fin ? 0 : 9;
        default: nph = 0;
      endcase
      if (!en_i) nf = 0; else if (m_e2 && conv) nf = 1; else nf = m_fault;
      if (nph != ph_o) m_cnt = 0;
      else if (tick_i && m_cnt < 100000) m_cnt++;
      if (ph_o == 0 || ph_o == 5) m_duty = duty_i;
      if (!ex_run(ph_o)) begin m_pre = 0; m_step = 0; end
      else if (m_pre == P_DIV - 1) begin m_pre = 0; m_step = (m_step + 1) % 256; end
      else m_pre++;
      m_e2 = m_e1; m_e1 = conv_err_i;
      m_ph = nph; m_fault = nf[0];
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      int eff;
      eff = (m_duty < P_DMIN) ? P_DMIN : m_duty;
      chk("R2 R3 R4 R9", "panel", panel_pwr_o, m_ph != 0);
      chk("R2 R3 R9", "link", link_en_o, ex_link(m_ph));
      chk("R2 R3 R8 R9", "conv", bl_pwr_o, ex_conv(m_ph));
      chk("R2 R3 R8", "blon", bl_on_o, m_ph == 5);
      chk("R5 R6 R7", "pwm", pwm_o, ex_run(m_ph) && (m_step < eff));
      chk("R8 R10", "fault", fault_o, m_fault);
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "panel", panel_pwr_o, 0);
    chk("R1", "link", link_en_o, 0);
    chk("R1", "conv", bl_pwr_o, 0);
    chk("R1", "pwm", pwm_o, 0);
    chk("R1", "blon", bl_on_o, 0);
    chk("R1", "fault", fault_o, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    chk("R1", "panel after release", panel_pwr_o, 0);

    // R6 R7: small duty captured in idle, large value offered during ramp
    duty_i = 8'd5;
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    for (int i = 0; i < 500 && !link_en_o; i++) @(negedge clk);
    duty_i = 8'd200;
    for (int i = 0; i < 2000 && !pwm_o; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R6", "frozen clamped duty", pwm_o, 0);
    chk("R7", "still ramping", bl_on_o, 0);
    for (int i = 0; i < 2000 && !bl_on_o; i++) @(negedge clk);
    chk("R2", "blon reached", bl_on_o, 1);
    repeat (1100) @(negedge clk);

    // R3 full descent then R4 hold
    en_i = 1'b0;
    @(negedge clk);
    chk("R3", "blon first off", bl_on_o, 0);
    chk("R3", "conv still on", bl_pwr_o, 1);
    for (int i = 0; i < 500 && panel_pwr_o; i++) @(negedge clk);
    en_i = 1'b1;
    repeat (20) @(negedge clk);
    chk("R4", "panel held off", panel_pwr_o, 0);

    // R9 abort in link settle
    for (int i = 0; i < 500 && !link_en_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk("R9", "link dropped", link_en_o, 0);
    chk("R9", "panel kept", panel_pwr_o, 1);
    for (int i = 0; i < 500 && panel_pwr_o; i++) @(negedge clk);
    en_i = 1'b1;
    // R9 abort in converter phase
    for (int i = 0; i < 1000 && !bl_pwr_o; i++) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk("R9", "conv dropped", bl_pwr_o, 0);
    chk("R9", "link kept", link_en_o, 1);
    for (int i = 0; i < 500 && panel_pwr_o; i++) @(negedge clk);

    // R10 error while converter unpowered
    conv_err_i = 1'b1;
    en_i = 1'b1;
    for (int i = 0; i < 500 && !link_en_o; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R10", "no fault", fault_o, 0);
    chk("R10", "link up", link_en_o, 1);
    conv_err_i = 1'b0;
    for (int i = 0; i < 2000 && !bl_on_o; i++) @(negedge clk);
    chk("R10", "reached on", bl_on_o, 1);

    // R8 trip while on
    repeat (50) @(negedge clk);
    conv_err_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "fault set", fault_o, 1);
    chk("R8", "blon off", bl_on_o, 0);
    conv_err_i = 1'b0;
    for (int i = 0; i < 500 && panel_pwr_o; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R8", "stays off", panel_pwr_o, 0);
    chk("R8", "fault held", fault_o, 1);
    en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "fault cleared", fault_o, 0);
    repeat (5) @(negedge clk);
    summary();
  end

endmodule